// File: doc/BRIEF.md
# Programmable field sequence selector

The block plays back an ordered list of field-timing indices, one per vertical frame. A 24-bit mode word packs a count and up to seven 3-bit selectors. The block presents the active field index to the downstream timing generators and steps to the next selector on every vertical-sync (VD) pulse. After the last counted selector it returns to the first, and it keeps looping until a new mode word arrives.

A new word is checked the cycle it is written. A legal word is held as pending and takes over at the next VD, starting from its first selector, so the field already running finishes on its old timing. An illegal word is dropped. The sequence in force and any legal pending word are kept, and a sticky error flag is raised.

Top module: `field_seq_sel`

## Requirements
- R1: After reset `valid_o`, `err_o` and `field_o` are all 0, and `field_o` stays 0 while `valid_o` is low.
- R2: Mode word layout: bits 23:21 hold the count of fields to use. Selector k (k = 0..6) sits at bits 3k+2:3k, so selector 0 is bits 2:0 and selector 6 is bits 20:18. Playback begins with selector 0. For example, 0x600088 plays 0,1,2; 0x400023 plays 3,4; 0x80050D plays 5,1,4,2.
- R3: A legal write has no effect on `field_o` until the next VD pulse. The output changes in the cycle after that VD, showing selector 0 of the new word.
- R4: Each VD pulse moves `field_o` to the next selector. After the selector numbered count-1 the next VD returns to selector 0, and the loop repeats indefinitely.
- R5: A write with count 0 is rejected. `err_o` reads 1 from the cycle after the write, and the sequence in force carries on unchanged.
- R6: A write whose active selectors (those numbered below the count) contain code 6 or 7 is rejected in the same way as R5. A legal word that is already pending stays pending.
- R7: Selectors numbered at or above the count are neither played nor checked, so 0x2FFFF8 is legal and plays 0 forever.
- R8: `err_o` stays high across VD pulses and illegal writes. It returns to 0 in the cycle after the next legal write.
- R9: When VD and a write happen in the same cycle, that VD steps the old sequence. The new word takes effect at the following VD.
- R10: `field_o` and `valid_o` change only in the cycle after a VD pulse. Once `valid_o` is high it stays high until reset.
- R11: A VD pulse before any legal write leaves `valid_o` at 0. The first VD after a legal write sets `valid_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Mode word write strobe |
| wr_data_i | input | 24 | Mode word |
| vd_i | input | 1 | Single-cycle vertical-sync pulse |
| field_o | output | 3 | Active field index |
| valid_o | output | 1 | A sequence is loaded and playing |
| err_o | output | 1 | Sticky flag for a rejected mode word |

## Verification
The bench targets the wrap point for counts 1, 2, 3, 4 and 7. A design with an off-by-one in the pointer would play one selector too many or too few, or would stall at the end of the list.

It writes illegal words both with a sequence playing and with a legal word pending. A design that loads rejected words would jump to a garbage field. A design that clears the pending word on rejection would never switch to the pending word.

It also drives a write in the same cycle as VD, and loads a word with junk in the unused selectors. Mishandling either case would show up as an early switch or as a false error.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam int unsigned FSEQ_SLOTS  = 7;
  localparam int unsigned FSEQ_SEL_W  = 3;
  localparam int unsigned FSEQ_FIELDS = 6;
  localparam int unsigned FSEQ_CNT_W  = $clog2(FSEQ_SLOTS + 1);
  localparam int unsigned FSEQ_WORD_W = FSEQ_CNT_W + FSEQ_SLOTS * FSEQ_SEL_W;
endpackage

// File: rtl/fseq_mode_chk.sv
module fseq_mode_chk
  import fseq_pkg::*;
#(
  parameter int unsigned SLOTS  = FSEQ_SLOTS,
  parameter int unsigned SEL_W  = FSEQ_SEL_W,
  parameter int unsigned FIELDS = FSEQ_FIELDS,
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1),
  localparam int unsigned WORD_W = CNT_W + SLOTS * SEL_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              legal_o
);
  logic [CNT_W-1:0] cnt;
  logic [SLOTS-1:0] slot_ok;

  assign cnt = word_i[WORD_W-1 -: CNT_W];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [SEL_W-1:0] sel;
    assign sel = word_i[k*SEL_W +: SEL_W];
    // unused slots are don't-care
    assign slot_ok[k] = (32'(cnt) <= k) || (32'(sel) < FIELDS);
  end

  assign legal_o = (cnt != '0) && (32'(cnt) <= SLOTS) && (&slot_ok);
endmodule

// File: rtl/fseq_ptr.sv
module fseq_ptr
  import fseq_pkg::*;
#(
  parameter int unsigned SLOTS = FSEQ_SLOTS,
  localparam int unsigned CNT_W = $clog2(SLOTS + 1),
  localparam int unsigned PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic last;

  assign last = (CNT_W'(ptr_o) + CNT_W'(1)) >= cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= '0;
    else if (step_i) ptr_o <= last ? '0 : ptr_o + PTR_W'(1);
  end
endmodule

// File: rtl/field_seq_sel.sv
module field_seq_sel
  import fseq_pkg::*;
#(
  parameter int unsigned SLOTS  = FSEQ_SLOTS,
  parameter int unsigned SEL_W  = FSEQ_SEL_W,
  parameter int unsigned FIELDS = FSEQ_FIELDS,
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1),
  localparam int unsigned WORD_W = CNT_W + SLOTS * SEL_W,
  localparam int unsigned PTR_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              vd_i,
  output logic [SEL_W-1:0]  field_o,
  output logic              valid_o,
  output logic              err_o
);
  logic [WORD_W-1:0] pend_q, act_q;
  logic              pend_vld_q;
  logic              wr_legal;
  logic              load, step;
  logic [PTR_W-1:0]  ptr;
  logic [SEL_W-1:0]  sel_arr [SLOTS];

  fseq_mode_chk #(.SLOTS(SLOTS), .SEL_W(SEL_W), .FIELDS(FIELDS)) u_mode_chk (
    .word_i  (wr_data_i),
    .legal_o (wr_legal)
  );

  // VD consumes the pending word seen before this cycle's write
  assign load = vd_i && pend_vld_q;
  assign step = vd_i && valid_o && !pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      act_q      <= '0;
      valid_o    <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      if (wr_i) begin
        if (wr_legal) begin
          pend_q <= wr_data_i;
          err_o  <= 1'b0;
        end else begin
          err_o  <= 1'b1;
        end
      end
      if (wr_i && wr_legal) pend_vld_q <= 1'b1;
      else if (vd_i)        pend_vld_q <= 1'b0;
      if (load) begin
        act_q   <= pend_q;
        valid_o <= 1'b1;
      end
    end
  end

  fseq_ptr #(.SLOTS(SLOTS)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .cnt_i  (act_q[WORD_W-1 -: CNT_W]),
    .ptr_o  (ptr)
  );

  for (genvar k = 0; k < SLOTS; k++) begin : g_sel
    assign sel_arr[k] = act_q[k*SEL_W +: SEL_W];
  end

  assign field_o = valid_o ? sel_arr[ptr] : '0;
endmodule

// File: rtl/field_seq_sel_chk.sv
module field_seq_sel_chk #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned FIELDS = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic              vd_i,
  input logic [SEL_W-1:0]  field_o,
  input logic              valid_o,
  input logic              err_o
);
  // R10
  field_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vd_i |=> ($stable(field_o) && $stable(valid_o)));
  // R10
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);
  // R11
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(vd_i));
  // R5
  cnt_zero_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (wr_data_i[WORD_W-1 -: CNT_W] == '0)) |=> err_o);
  // R8
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(wr_i));
  // R6
  field_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (32'(field_o) < FIELDS));
  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (field_o == '0));
endmodule

bind field_seq_sel field_seq_sel_chk #(
  .WORD_W(WORD_W), .SEL_W(SEL_W), .CNT_W(CNT_W), .FIELDS(FIELDS)
) u_field_seq_sel_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .wr_data_i (wr_data_i),
  .vd_i      (vd_i),
  .field_o   (field_o),
  .valid_o   (valid_o),
  .err_o     (err_o)
);

// File: tb/tb_field_seq_sel.sv
`timescale 1ns/1ps
module tb_field_seq_sel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [23:0] wr_data_i = '0;
  logic        vd_i = 1'b0;
  logic [2:0]  field_o;
  logic        valid_o;
  logic        err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  field_seq_sel dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .vd_i(vd_i), .field_o(field_o), .valid_o(valid_o), .err_o(err_o)
  );

  // {len[3:0], word[23:0], expected fields one per nibble, first lowest}
  localparam logic [55:0] VEC [5] = '{
    {4'd3, 24'h600088, 28'h0000210},
    {4'd2, 24'h400023, 28'h0000043},
    {4'd4, 24'h80050D, 28'h0002415},
    {4'd7, 24'hF414E5, 28'h5012345},
    {4'd1, 24'h2FFFF8, 28'h0000000}
  };

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write(logic [23:0] w);
    @(negedge clk_i); wr_i = 1'b1; wr_data_i = w;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic pulse_vd();
    @(negedge clk_i); vd_i = 1'b1;
    @(negedge clk_i); vd_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk_i);
  endtask

  initial begin
    int prev;
    logic [27:0] sq;
    int len;
    repeat (3) @(negedge clk_i);
    check("R1 valid", valid_o, 0);
    check("R1 err", err_o, 0);
    check("R1 field", field_o, 0);
    rst_ni = 1'b1;
    idle();
    check("R1 valid after release", valid_o, 0);

    pulse_vd();
    check("R11 vd before write", valid_o, 0);
    check("R11 field before write", field_o, 0);

    prev = 0;
    for (int v = 0; v < 5; v++) begin
      len = int'(VEC[v][55:52]);
      sq  = VEC[v][27:0];
      write(VEC[v][51:28]);
      idle(); idle();
      check("R3 field held until VD", field_o, prev);
      check("R7 legal word no error", err_o, 0);
      for (int j = 0; j < 10; j++) begin
        pulse_vd();
        prev = int'(sq[(j % len) * 4 +: 3]);
        if (j == 0) begin
          check("R11 valid after VD", valid_o, 1);
          check("R2 first selector", field_o, prev);
        end else begin
          check("R4 step and wrap", field_o, prev);
        end
      end
    end

    // directed: active 0x2FFFF8, field 0
    write(24'h600088);
    pulse_vd(); check("R3 new word at VD", field_o, 0);
    pulse_vd(); check("R4 step", field_o, 1);

    write(24'h000088);
    check("R5 count zero err", err_o, 1);
    pulse_vd(); check("R5 old sequence continues", field_o, 2);
    pulse_vd(); check("R5 old sequence wraps", field_o, 0);

    write(24'h600188);
    check("R6 bad selector err", err_o, 1);
    pulse_vd(); check("R6 old sequence continues", field_o, 1);
    check("R8 err sticky over VD", err_o, 1);

    write(24'h400023);
    check("R8 err cleared by legal write", err_o, 0);
    idle();
    check("R3 field held after write", field_o, 1);
    pulse_vd(); check("R3 new word at VD", field_o, 3);

    write(24'h600088);
    write(24'h400038);
    check("R6 bad last active selector", err_o, 1);
    pulse_vd(); check("R6 pending kept", field_o, 0);
    pulse_vd(); check("R4 step", field_o, 1);
    check("R8 err still set", err_o, 1);

    write(24'h400023);
    check("R8 err cleared", err_o, 0);
    pulse_vd(); check("R3 load", field_o, 3);

    @(negedge clk_i); vd_i = 1'b1; wr_i = 1'b1; wr_data_i = 24'h80050D;
    @(negedge clk_i); vd_i = 1'b0; wr_i = 1'b0;
    check("R9 VD uses old sequence", field_o, 4);
    idle();
    check("R10 no change without VD", field_o, 4);
    pulse_vd(); check("R9 new word at next VD", field_o, 5);
    pulse_vd(); check("R9 new sequence steps", field_o, 1);
    check("R10 valid held", valid_o, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule